// File: doc/BRIEF.md
# External Interrupt Line Controller

This block takes 28 asynchronous external request pins and turns them into four grouped interrupt outputs for a downstream interrupt controller. Each pin is synchronized and then watched for a trigger condition chosen by software: an active-low level, an active-high level, a falling edge, a rising edge or either edge. A detected condition sets a sticky pending bit. A mask register decides which pending bits reach the outputs. Each output is the OR of the unmasked pending bits in its own range of lines, and the ranges are not all the same size.

Software reaches the block through a flat register port. A write is a single-cycle strobe. Read data is returned combinationally from the address. The port exposes two trigger configuration words, the mask word and the pending word. Adjacent line pairs share one trigger setting, so each configuration word holds up to eight pair settings, one per nibble. A handler reads the pending word, services its lines, and clears them by writing ones.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the mask word (offset 0x08) reads 0x0FFFFFFF, both configuration words read 0, and all four group outputs are low.
- R2: A pin change reaches the pending bit and its group output on the third rising clock edge after the change, through two synchronizer stages and one pending register stage.
- R3: Field value 000 selects low-level trigger and 001 selects high-level trigger. While the active level is present the pending bit is set on every cycle, so a clear write has no lasting effect until the level has gone away.
- R4: Field values 01x select falling edge, 10x select rising edge and 11x select both edges. An edge of the other polarity sets nothing.
- R5: Lines 2k and 2k+1 share one 3-bit field. Lines 0-15 use the word at offset 0x00 and lines 16-27 use the word at offset 0x04. Pair k sits at bits [4j+2:4j] of its word, where j is k modulo 8. Bit 3 of each nibble reads 0, and so do bits 31:24 of the second word.
- R6: In the mask word a 1 in bit n blocks line n from its group output. A masked line still latches its pending bit, and unmasking it drives the group output high.
- R7: In the pending word (offset 0x0C), writing 1 to bit n clears line n. Writing 0 leaves that bit unchanged.
- R8: When a trigger event and a clear write hit the same pending bit in the same cycle, the bit ends up set.
- R9: Output bit 0 covers lines 0-3, bit 1 covers lines 4-11, bit 2 covers lines 12-19 and bit 3 covers lines 20-27.
- R10: Bits 31:28 of the mask word and the pending word always read 0, and writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 28 | Asynchronous external request pins |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_we_i | input | 1 | Single-cycle write strobe |
| reg_rdata_o | output | 32 | Combinational read data |
| irq_grp_o | output | 4 | Grouped interrupt outputs |

## Verification
The hardest case to reach from the ports is a clear write and a fresh edge landing on the same pending bit in the same clock cycle. The bench reaches it by counting the synchronizer latency. It toggles the pin on a falling clock edge, lets two rising edges pass, and then issues the clear write so that it commits on the same edge that latches the event. A clear one cycle later then proves that the bit was really set again and was not simply left untouched. The level-mode case, where a clear has no effect while the level is still present, is reached by holding the pin active across the write and reading back afterwards.

// File: rtl/eint_pkg.sv
package eint_pkg;

  typedef enum logic [2:0] {
    TRIG_LOW,
    TRIG_HIGH,
    TRIG_FALL,
    TRIG_RISE,
    TRIG_BOTH
  } trig_e;

  localparam int CFG_OFS  = 'h00;
  localparam int MASK_OFS = 'h08;
  localparam int PEND_OFS = 'h0C;

  function automatic trig_e trig_decode(input logic [2:0] f);
    case (f[2:1])
      2'b00:   return f[0] ? TRIG_HIGH : TRIG_LOW;
      2'b01:   return TRIG_FALL;
      2'b10:   return TRIG_RISE;
      default: return TRIG_BOTH;
    endcase
  endfunction

  // first line of group g: a short leading group, then equal-width groups
  function automatic int grp_first(input int g, input int lead_w, input int grp_w);
    return (g == 0) ? 0 : lead_w + grp_w * (g - 1);
  endfunction

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int N = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);

  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign cur_o  = sync_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/eint_detect.sv
module eint_detect
  import eint_pkg::*;
#(
  parameter int N      = 28,
  parameter int NPAIRS = (N + 1) / 2
) (
  input  logic [NPAIRS-1:0][2:0] field_i,
  input  logic [N-1:0]           cur_i,
  input  logic [N-1:0]           prev_i,
  output logic [N-1:0]           evt_o
);

  for (genvar i = 0; i < N; i++) begin : g_line
    trig_e mode;
    assign mode = trig_decode(field_i[i/2]);
    always_comb begin
      case (mode)
        TRIG_LOW:  evt_o[i] = ~cur_i[i];
        TRIG_HIGH: evt_o[i] = cur_i[i];
        TRIG_FALL: evt_o[i] = prev_i[i] & ~cur_i[i];
        TRIG_RISE: evt_o[i] = ~prev_i[i] & cur_i[i];
        default:   evt_o[i] = prev_i[i] ^ cur_i[i];
      endcase
    end
  end

endmodule

// File: rtl/eint_regs.sv
module eint_regs
  import eint_pkg::*;
#(
  parameter int N      = 28,
  parameter int DW     = 32,
  parameter int AW     = 8,
  parameter int NPAIRS = (N + 1) / 2,
  parameter int PPR    = DW / 4,
  parameter int NCFG   = (NPAIRS + PPR - 1) / PPR
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic                   we_i,
  output logic [DW-1:0]          rdata_o,
  input  logic [N-1:0]           evt_i,
  output logic [NPAIRS-1:0][2:0] field_o,
  output logic [N-1:0]           mask_o,
  output logic [N-1:0]           pend_o,
  output logic [N-1:0]           clr_o
);

  logic [NPAIRS-1:0][2:0]  field_q;
  logic [N-1:0]            mask_q, pend_q;
  logic [NCFG-1:0]         cfg_hit;
  logic [NCFG-1:0][DW-1:0] cfg_word;
  logic                    mask_hit, pend_hit;
  logic                    unused_wdata;

  for (genvar j = 0; j < NCFG; j++) begin : g_hit
    assign cfg_hit[j] = (addr_i == AW'(CFG_OFS + 4 * j));
  end
  assign mask_hit = (addr_i == AW'(MASK_OFS));
  assign pend_hit = (addr_i == AW'(PEND_OFS));

  assign clr_o        = (we_i && pend_hit) ? wdata_i[N-1:0] : '0;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= '0;
    end else if (we_i) begin
      for (int p = 0; p < NPAIRS; p++) begin
        if (cfg_hit[p/PPR]) field_q[p] <= wdata_i[4*(p%PPR) +: 3];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              mask_q <= '1;
    else if (we_i && mask_hit) mask_q <= wdata_i[N-1:0];
  end

  // new events override a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_o) | evt_i;
  end

  always_comb begin
    cfg_word = '0;
    for (int p = 0; p < NPAIRS; p++) begin
      cfg_word[p/PPR][4*(p%PPR) +: 3] = field_q[p];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int j = 0; j < NCFG; j++) begin
      if (cfg_hit[j]) rdata_o = cfg_word[j];
    end
    if (mask_hit) rdata_o[N-1:0] = mask_q;
    if (pend_hit) rdata_o[N-1:0] = pend_q;
  end

  assign field_o = field_q;
  assign mask_o  = mask_q;
  assign pend_o  = pend_q;

endmodule

// File: rtl/eint_group.sv
module eint_group
  import eint_pkg::*;
#(
  parameter int N      = 28,
  parameter int G      = 4,
  parameter int LEAD_W = 4,
  parameter int GRP_W  = 8
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  output logic [G-1:0] irq_o
);

  logic [N-1:0] live;
  assign live = pend_i & ~mask_i;

  for (genvar g = 0; g < G; g++) begin : g_grp
    localparam int LO = grp_first(g, LEAD_W, GRP_W);
    localparam int HI = (g == G - 1) ? N - 1 : grp_first(g + 1, LEAD_W, GRP_W) - 1;
    assign irq_o[g] = |live[HI:LO];
  end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NUM_LINES = 28,
  parameter int NUM_GRP   = 4,
  parameter int LEAD_W    = 4,
  parameter int GRP_W     = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  input  logic                 reg_we_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic [NUM_GRP-1:0]   irq_grp_o
);

  localparam int NPAIRS = (NUM_LINES + 1) / 2;

  logic [NUM_LINES-1:0]   cur, prev, evt, mask_q, pend_q, clr;
  logic [NPAIRS-1:0][2:0] field;

  eint_sync #(.N(NUM_LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .cur_o (cur),
    .prev_o(prev)
  );

  eint_detect #(.N(NUM_LINES), .NPAIRS(NPAIRS)) u_detect (
    .field_i(field),
    .cur_i  (cur),
    .prev_i (prev),
    .evt_o  (evt)
  );

  eint_regs #(.N(NUM_LINES), .DW(DATA_W), .AW(ADDR_W), .NPAIRS(NPAIRS)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .we_i   (reg_we_i),
    .rdata_o(reg_rdata_o),
    .evt_i  (evt),
    .field_o(field),
    .mask_o (mask_q),
    .pend_o (pend_q),
    .clr_o  (clr)
  );

  eint_group #(.N(NUM_LINES), .G(NUM_GRP), .LEAD_W(LEAD_W), .GRP_W(GRP_W)) u_group (
    .pend_i(pend_q),
    .mask_i(mask_q),
    .irq_o (irq_grp_o)
  );

endmodule

// File: rtl/eint_chk.sv
module eint_chk
  import eint_pkg::*;
#(
  parameter int N  = 28,
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int G  = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  evt,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  clr,
  input logic [G-1:0]  irq,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata
);

  // R2/R8: every detected event is latched on the next edge, clear or not
  a_r8_event_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend & $past(evt)) == $past(evt)));

  // R4: a pending bit only rises because of an event
  a_r4_set_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(evt)) == '0));

  // R7: a pending bit only falls through a clear write
  a_r7_hold_without_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend) & ~pend & ~$past(clr)) == '0));

  // R6: fully masked means no output
  a_r6_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask) |-> (irq == '0));

  // R10: reserved upper bits of mask and pending words read zero
  a_r10_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr == AW'(MASK_OFS)) || (addr == AW'(PEND_OFS))) |-> (rdata[DW-1:N] == '0));

endmodule

bind ext_irq_ctrl eint_chk #(
  .N(NUM_LINES), .DW(DATA_W), .AW(ADDR_W), .G(NUM_GRP)
) u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .evt  (evt),
  .pend (pend_q),
  .mask (mask_q),
  .clr  (clr),
  .irq  (irq_grp_o),
  .addr (reg_addr_i),
  .rdata(reg_rdata_o)
);

// File: tb/tb_ext_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ext_irq_ctrl;

  localparam logic [7:0] A_CLO = 8'h00, A_CHI = 8'h04, A_MSK = 8'h08, A_PND = 8'h0C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] pins = '1;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_we_i(we), .reg_rdata_o(rdata), .irq_grp_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic setpin(input int n, input logic v);
    @(negedge clk); pins[n] = v;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] grp_of(input int n);
    if (n < 4) return 4'b0001;
    if (n < 12) return 4'b0010;
    if (n < 20) return 4'b0100;
    return 4'b1000;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(A_MSK, d); check("R1 mask reset", d, 32'h0FFF_FFFF);
    rd(A_CLO, d); check("R1 cfg lo reset", d, 0);
    rd(A_CHI, d); check("R1 cfg hi reset", d, 0);
    check("R1 irq reset", {28'd0, irq}, 0);
    wr(A_CLO, 32'h4444_4444);
    wr(A_CHI, 32'h0044_4444);
    wr(A_PND, 32'hFFFF_FFFF);
    wr(A_MSK, 32'h0);
    rd(A_PND, d); check("R7 setup clear", d, 0);
    check("R6 setup irq", {28'd0, irq}, 0);
  endtask

  task automatic t_rise_latency();
    logic [31:0] d;
    setpin(5, 1'b0); settle();
    rd(A_PND, d); check("R4 fall ignored in rise mode", d, 0);
    @(negedge clk); pins[5] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 not before third edge", {28'd0, irq}, 0);
    @(posedge clk); @(negedge clk);
    check("R2 third edge irq", {28'd0, irq}, 32'h2);
    rd(A_PND, d); check("R4 rise pending", d, 32'h20);
    wr(A_PND, 32'h20);
    check("R7 cleared irq", {28'd0, irq}, 0);
  endtask

  task automatic t_groups();
    int lines [7] = '{3, 4, 11, 12, 19, 20, 27};
    foreach (lines[i]) begin
      setpin(lines[i], 1'b0); settle();
      setpin(lines[i], 1'b1); settle();
      check($sformatf("R9 group of line %0d", lines[i]), {28'd0, irq}, {28'd0, grp_of(lines[i])});
      wr(A_PND, 32'h1 << lines[i]);
    end
  endtask

  task automatic t_fall_both();
    logic [31:0] d;
    wr(A_CLO, 32'h4444_4344);
    setpin(4, 1'b0); settle();
    rd(A_PND, d); check("R4 falling line 4", d, 32'h10);
    setpin(5, 1'b0); settle();
    rd(A_PND, d); check("R5 shared field line 5", d, 32'h30);
    wr(A_PND, 32'h30);
    setpin(4, 1'b1); setpin(5, 1'b1); settle();
    rd(A_PND, d); check("R4 rise ignored in fall mode", d, 0);
    wr(A_CHI, 32'h0074_4444);
    setpin(27, 1'b0); settle();
    rd(A_PND, d); check("R4 both fall line 27", d, 32'h0800_0000);
    check("R9 line 27 group", {28'd0, irq}, 32'h8);
    wr(A_PND, 32'h0800_0000);
    setpin(27, 1'b1); settle();
    rd(A_PND, d); check("R4 both rise line 27", d, 32'h0800_0000);
    wr(A_PND, 32'h0800_0000);
    setpin(26, 1'b0); settle();
    rd(A_PND, d); check("R5 line 26 shares pair 13", d, 32'h0400_0000);
    setpin(26, 1'b1); settle();
    wr(A_PND, 32'h0C00_0000);
    wr(A_CLO, 32'h4444_4444);
    wr(A_CHI, 32'h0044_4444);
  endtask

  task automatic t_cfg_readback();
    logic [31:0] d;
    wr(A_CHI, 32'hFFFF_FFFF);
    rd(A_CHI, d); check("R5 cfg hi readback", d, 32'h0077_7777);
    wr(A_CLO, 32'h8888_8888);
    rd(A_CLO, d); check("R5 nibble bit3 reads 0", d, 0);
    rd(A_PND, d); check("R3 low level no event with pins high", d, 0);
    wr(A_CLO, 32'h4444_4444);
    wr(A_CHI, 32'h0044_4444);
  endtask

  task automatic t_level();
    logic [31:0] d;
    setpin(12, 1'b0); setpin(13, 1'b0); settle();
    wr(A_CLO, 32'h4144_4444);
    wr(A_PND, 32'hFFFF_FFFF);
    rd(A_PND, d); check("R3 high level idle", d, 0);
    setpin(12, 1'b1); settle();
    rd(A_PND, d); check("R3 high level sets", d, 32'h1000);
    wr(A_PND, 32'h1000);
    rd(A_PND, d); check("R3 clear ignored while high", d, 32'h1000);
    setpin(12, 1'b0); settle();
    rd(A_PND, d); check("R3 stays latched", d, 32'h1000);
    wr(A_PND, 32'h1000);
    rd(A_PND, d); check("R3 clear after level gone", d, 0);
    wr(A_CLO, 32'h0144_4444);
    setpin(15, 1'b0); settle();
    rd(A_PND, d); check("R3 low level sets", d, 32'h8000);
    wr(A_PND, 32'h8000);
    rd(A_PND, d); check("R3 clear ignored while low", d, 32'h8000);
    setpin(15, 1'b1); settle();
    wr(A_PND, 32'h8000);
    rd(A_PND, d); check("R3 low clear after release", d, 0);
    wr(A_CLO, 32'h4444_4444);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_MSK, 32'h100);
    setpin(8, 1'b0); settle();
    setpin(8, 1'b1); settle();
    check("R6 masked irq low", {28'd0, irq}, 0);
    rd(A_PND, d); check("R6 masked still pending", d, 32'h100);
    wr(A_MSK, 32'h0);
    check("R6 unmask exposes", {28'd0, irq}, 32'h2);
    wr(A_PND, 32'h100);
  endtask

  task automatic t_clear_zero();
    logic [31:0] d;
    setpin(0, 1'b0); setpin(1, 1'b0); settle();
    setpin(0, 1'b1); setpin(1, 1'b1); settle();
    rd(A_PND, d); check("R7 two pending", d, 32'h3);
    wr(A_PND, 32'h1);
    rd(A_PND, d); check("R7 write1 clears only bit0", d, 32'h2);
    wr(A_PND, 32'h0);
    rd(A_PND, d); check("R7 write0 no effect", d, 32'h2);
    wr(A_PND, 32'h2);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    setpin(20, 1'b0); settle();
    @(negedge clk); pins[20] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(A_PND, 32'h0010_0000);
    rd(A_PND, d); check("R8 set beats clear", d, 32'h0010_0000);
    wr(A_PND, 32'h0010_0000);
    rd(A_PND, d); check("R8 later clear works", d, 0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(A_MSK, 32'hFFFF_FFFF);
    rd(A_MSK, d); check("R10 mask upper bits", d, 32'h0FFF_FFFF);
    wr(A_MSK, 32'h0);
    wr(A_PND, 32'hF000_0000);
    rd(A_PND, d); check("R10 pending upper bits", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rise_latency();
    t_groups();
    t_fall_both();
    t_cfg_readback();
    t_level();
    t_mask();
    t_clear_zero();
    t_set_wins();
    t_reserved();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule